// File: doc/BRIEF.md
# Control Payload Key-Value Parser

This block walks the byte stream of a control-channel payload and splits it into key/type/length/value records. Each record opens with a six-byte header: a four-byte key, then a 16-bit word whose upper nibble is the data type and whose lower twelve bits give the value length in bytes. That many value bytes follow the header. For every record the parser raises a one-cycle descriptor that carries the key, type and length. It then passes the value bytes through one at a time and marks the final one. A header made of a zero key and type 0 ends the record list and produces no descriptor.

The stream arrives one byte per cycle when `in_valid` is high. `in_sop` marks the first byte of a payload and `in_eop` marks the last. There is no backpressure. When the last byte arrives the parser reports how the payload ended: cleanly at the terminator, truncated, or cut off while a record still owed value bytes. The parser does not interpret values and does not rebuild payloads that span several packets.

Top module: `ctl_tlv_parser`

## Requirements
- R1: Header bytes 0..3 of a record form the key, most significant byte first. The upper nibble of byte 4 is the type. The lower nibble of byte 4 is length bits 11:8 and byte 5 is length bits 7:0. `desc_valid` pulses for one cycle, in the cycle after the sixth header byte is accepted, with `desc_key`, `desc_type` and `desc_len` holding those fields.
- R2: Each value byte of a record appears on `val_data` with `val_valid` one cycle after it is accepted, in input order. `val_last` is high only on the value byte whose count equals the declared length.
- R3: A record with length 0 produces a descriptor and no value bytes. The byte that follows it is the first key byte of the next header.
- R4: `desc_bad_type` is 1 for types 4 through 14 and 0 for types 0, 1, 2, 3 and 15. The value bytes of a reserved-type record are still passed through by length, so the records after it stay aligned.
- R5: A header whose key is zero and whose type is 0 is the terminator. It produces no descriptor. Bytes after it up to the end of the payload produce no output.
- R6: One cycle after a byte with `in_eop` is accepted inside a payload, `end_valid` pulses. Exactly one of `end_ok`, `end_trunc` and `end_overrun` is set with it. `end_ok` is set when the terminator was fully received by that byte.
- R7: `end_trunc` is set when the payload ends without a terminator and no value bytes are owed: either part way through a header, or exactly at the end of a record.
- R8: `end_overrun` is set when the payload ends while the current record still owes value bytes. This includes a payload that ends on the sixth byte of a header with nonzero length. `val_last` is never raised for such a record.
- R9: A byte with `in_sop` restarts parsing, and that byte is treated as key byte 0 even in the middle of a record. Bytes accepted outside a payload are ignored and produce no output.
- R10: While `rst` is high and after it is released, all output strobes and flags are 0 until input arrives.
- R11: Cycles with `in_valid` low change no parser state and produce no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte present this cycle |
| in_data | input | 8 | Input byte |
| in_sop | input | 1 | First byte of a payload |
| in_eop | input | 1 | Last byte of a payload |
| desc_valid | output | 1 | Record descriptor strobe |
| desc_key | output | 32 | Record key, first byte most significant |
| desc_type | output | 4 | Record data type |
| desc_len | output | 12 | Record value length in bytes |
| desc_bad_type | output | 1 | Type code is reserved (4..14) |
| val_valid | output | 1 | Value byte strobe |
| val_data | output | 8 | Value byte |
| val_last | output | 1 | Final value byte of the record |
| end_valid | output | 1 | End-of-payload report strobe |
| end_ok | output | 1 | Payload ended after the terminator |
| end_trunc | output | 1 | Payload ended without terminator, nothing owed |
| end_overrun | output | 1 | Payload ended with value bytes still owed |

## Verification
The bench targets the boundaries of the header and value phases. It sends a zero-length record, which a design with an off-by-one counter would treat as owing one byte, swallowing the next header and shifting every later record. It sends a length above 255, which checks that the length nibble is placed correctly. It sends reserved types followed by normal records, which shows whether parsing stays aligned after a bad type. It ends payloads at four points: mid-header, exactly at a record boundary, on a header with a nonzero length, and mid-value. A design that confused truncation with overrun, or that raised `val_last` on a cut-off record, would be caught here. It also sends a restart in the middle of a record, bytes outside any payload, bytes after the terminator and idle gaps between bytes, so any leakage into the outputs shows up as an unexpected item in the scoreboard.

// File: rtl/ctl_tlv_pkg.sv
package ctl_tlv_pkg;

    localparam int BYTE_W    = 8;
    localparam int KEY_BYTES = 4;
    localparam int TYPE_W    = 4;
    localparam int LEN_W     = 12;
    localparam int KEY_W     = KEY_BYTES * BYTE_W;
    localparam int HDR_BYTES = KEY_BYTES + (TYPE_W + LEN_W) / BYTE_W;
    localparam int HDR_W     = HDR_BYTES * BYTE_W;

    localparam logic [TYPE_W-1:0] TYPE_END       = 4'h0;
    localparam logic [TYPE_W-1:0] TYPE_RSVD_LO   = 4'h4;
    localparam logic [TYPE_W-1:0] TYPE_RSVD_HI   = 4'hE;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HDR,
        ST_VAL,
        ST_TAIL
    } pstate_e;

    // Field order matches arrival order: first byte lands in the top bits.
    typedef struct packed {
        logic [KEY_W-1:0]  key;
        logic [TYPE_W-1:0] typ;
        logic [LEN_W-1:0]  len;
    } rec_hdr_t;

    typedef struct packed {
        logic ok;
        logic trunc;
        logic overrun;
    } end_cls_t;

    function automatic logic type_reserved(input logic [TYPE_W-1:0] t);
        return (t >= TYPE_RSVD_LO) && (t <= TYPE_RSVD_HI);
    endfunction

    function automatic logic hdr_is_term(input rec_hdr_t h);
        return (h.key == '0) && (h.typ == TYPE_END);
    endfunction

endpackage

// File: rtl/tlv_hdr_collect.sv
module tlv_hdr_collect
    import ctl_tlv_pkg::*;
#(
    parameter int LANES = HDR_BYTES
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    take,
    input  logic                    restart,
    input  logic [BYTE_W-1:0]       data,
    output logic                    last_byte,
    output logic [LANES*BYTE_W-1:0] hdr_next
);
    localparam int IDX_W = $clog2(LANES);

    logic [IDX_W-1:0]  idx_q;
    logic [IDX_W-1:0]  cur_idx;
    logic [BYTE_W-1:0] lane_q [LANES];

    assign cur_idx   = restart ? '0 : idx_q;
    assign last_byte = (cur_idx == IDX_W'(LANES - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q <= '0;
        end else if (take) begin
            idx_q <= last_byte ? '0 : cur_idx + IDX_W'(1);
        end
    end

    // One register per byte lane; lane 0 holds the newest byte.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        if (g == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (take) lane_q[0] <= data;
            end
            assign hdr_next[BYTE_W-1:0] = data;
        end else begin : g_body
            always_ff @(posedge clk) begin
                if (take) lane_q[g] <= lane_q[g-1];
            end
            assign hdr_next[g*BYTE_W +: BYTE_W] = lane_q[g-1];
        end
    end

endmodule

// File: rtl/tlv_len_count.sv
module tlv_len_count
    import ctl_tlv_pkg::*;
#(
    parameter int CNT_W = LEN_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_len,
    input  logic             dec,
    output logic             at_last
);
    logic [CNT_W-1:0] rem_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q <= '0;
        end else if (load) begin
            rem_q <= load_len;
        end else if (dec) begin
            rem_q <= rem_q - CNT_W'(1);
        end
    end

    assign at_last = (rem_q == CNT_W'(1));

endmodule

// File: rtl/ctl_tlv_parser.sv
module ctl_tlv_parser
    import ctl_tlv_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_sop,
    input  logic              in_eop,
    output logic              desc_valid,
    output logic [KEY_W-1:0]  desc_key,
    output logic [TYPE_W-1:0] desc_type,
    output logic [LEN_W-1:0]  desc_len,
    output logic              desc_bad_type,
    output logic              val_valid,
    output logic [BYTE_W-1:0] val_data,
    output logic              val_last,
    output logic              end_valid,
    output logic              end_ok,
    output logic              end_trunc,
    output logic              end_overrun
);
    pstate_e    st_q, st_eff, st_nxt;
    logic       restart, accept;
    logic       hdr_take, val_take, hdr_last, hdr_done;
    logic       cnt_last, is_term;
    logic [HDR_W-1:0] hdr_word;
    rec_hdr_t   hv;
    end_cls_t   cls;

    assign restart  = in_valid && in_sop;
    assign st_eff   = restart ? ST_HDR : st_q;
    assign accept   = in_valid && (st_eff != ST_IDLE);
    assign hdr_take = in_valid && (st_eff == ST_HDR);
    assign val_take = in_valid && (st_eff == ST_VAL);
    assign hdr_done = hdr_take && hdr_last;

    tlv_hdr_collect #(.LANES(HDR_BYTES)) u_hdr (
        .clk       (clk),
        .rst       (rst),
        .take      (hdr_take),
        .restart   (restart),
        .data      (in_data),
        .last_byte (hdr_last),
        .hdr_next  (hdr_word)
    );

    assign hv      = rec_hdr_t'(hdr_word);
    assign is_term = hdr_is_term(hv);

    tlv_len_count #(.CNT_W(LEN_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (hdr_done && !is_term),
        .load_len (hv.len),
        .dec      (val_take),
        .at_last  (cnt_last)
    );

    always_comb begin
        st_nxt = st_q;
        if (in_valid) begin
            case (st_eff)
                ST_HDR: begin
                    if (hdr_last) begin
                        if (is_term)             st_nxt = ST_TAIL;
                        else if (hv.len == '0)   st_nxt = ST_HDR;
                        else                     st_nxt = ST_VAL;
                    end else begin
                        st_nxt = ST_HDR;
                    end
                end
                ST_VAL:  st_nxt = cnt_last ? ST_HDR : ST_VAL;
                ST_TAIL: st_nxt = ST_TAIL;
                default: st_nxt = ST_IDLE;
            endcase
            if (in_eop && st_eff != ST_IDLE) st_nxt = ST_IDLE;
        end
    end

    always_comb begin
        cls.ok      = (st_eff == ST_TAIL) || (hdr_done && is_term);
        cls.overrun = !cls.ok &&
                      (((st_eff == ST_VAL) && !cnt_last) ||
                       (hdr_done && !is_term && (hv.len != '0)));
        cls.trunc   = !cls.ok && !cls.overrun;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q          <= ST_IDLE;
            desc_valid    <= 1'b0;
            desc_key      <= '0;
            desc_type     <= '0;
            desc_len      <= '0;
            desc_bad_type <= 1'b0;
            val_valid     <= 1'b0;
            val_data      <= '0;
            val_last      <= 1'b0;
            end_valid     <= 1'b0;
            end_ok        <= 1'b0;
            end_trunc     <= 1'b0;
            end_overrun   <= 1'b0;
        end else begin
            st_q       <= st_nxt;
            desc_valid <= hdr_done && !is_term;
            if (hdr_done && !is_term) begin
                desc_key      <= hv.key;
                desc_type     <= hv.typ;
                desc_len      <= hv.len;
                desc_bad_type <= type_reserved(hv.typ);
            end
            val_valid <= val_take;
            val_last  <= val_take && cnt_last;
            if (val_take) val_data <= in_data;
            end_valid <= accept && in_eop;
            if (accept && in_eop) begin
                end_ok      <= cls.ok;
                end_trunc   <= cls.trunc;
                end_overrun <= cls.overrun;
            end else begin
                end_ok      <= 1'b0;
                end_trunc   <= 1'b0;
                end_overrun <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/ctl_tlv_checker.sv
module ctl_tlv_checker
    import ctl_tlv_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              in_eop,
    input logic              desc_valid,
    input logic [TYPE_W-1:0] desc_type,
    input logic [LEN_W-1:0]  desc_len,
    input logic              desc_bad_type,
    input logic              val_valid,
    input logic              val_last,
    input logic              end_valid,
    input logic              end_ok,
    input logic              end_trunc,
    input logic              end_overrun
);
    logic [LEN_W:0] vcnt_q;
    logic [LEN_W:0] vlen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            vcnt_q <= '0;
            vlen_q <= '0;
        end else if (desc_valid) begin
            vcnt_q <= '0;
            vlen_q <= {1'b0, desc_len};
        end else if (val_valid) begin
            vcnt_q <= val_last ? '0 : vcnt_q + 1'b1;
        end
    end

    AST_DESC_FROM_INPUT: assert property (@(posedge clk) disable iff (rst)
        desc_valid |-> $past(in_valid)); // R1

    AST_LAST_QUALIFIED: assert property (@(posedge clk) disable iff (rst)
        val_last |-> val_valid); // R2

    AST_LAST_AT_LENGTH: assert property (@(posedge clk) disable iff (rst)
        (val_valid && val_last) |-> ((vcnt_q + 1'b1) == vlen_q)); // R2

    AST_NO_EXTRA_VALUE: assert property (@(posedge clk) disable iff (rst)
        (val_valid && !val_last) |-> ((vcnt_q + 1'b1) < vlen_q)); // R2

    AST_DESC_VAL_APART: assert property (@(posedge clk) disable iff (rst)
        !(desc_valid && val_valid)); // R3

    AST_RESERVED_FLAG: assert property (@(posedge clk) disable iff (rst)
        desc_valid |-> (desc_bad_type == ((desc_type >= 4'h4) && (desc_type <= 4'hE)))); // R4

    AST_END_ONE_CLASS: assert property (@(posedge clk) disable iff (rst)
        end_valid |-> $onehot({end_ok, end_trunc, end_overrun})); // R6

    AST_END_FROM_EOP: assert property (@(posedge clk) disable iff (rst)
        end_valid |-> $past(in_valid && in_eop)); // R6

    AST_FLAGS_QUIET: assert property (@(posedge clk) disable iff (rst)
        !end_valid |-> ({end_ok, end_trunc, end_overrun} == 3'b000)); // R6

endmodule

bind ctl_tlv_parser ctl_tlv_checker u_chk (
    .clk           (clk),
    .rst           (rst),
    .in_valid      (in_valid),
    .in_eop        (in_eop),
    .desc_valid    (desc_valid),
    .desc_type     (desc_type),
    .desc_len      (desc_len),
    .desc_bad_type (desc_bad_type),
    .val_valid     (val_valid),
    .val_last      (val_last),
    .end_valid     (end_valid),
    .end_ok        (end_ok),
    .end_trunc     (end_trunc),
    .end_overrun   (end_overrun)
);

// File: tb/ctl_tlv_parser_tb.sv
module ctl_tlv_parser_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = '0;
    logic        in_sop = 1'b0;
    logic        in_eop = 1'b0;
    logic        desc_valid;
    logic [31:0] desc_key;
    logic [3:0]  desc_type;
    logic [11:0] desc_len;
    logic        desc_bad_type;
    logic        val_valid;
    logic [7:0]  val_data;
    logic        val_last;
    logic        end_valid;
    logic        end_ok;
    logic        end_trunc;
    logic        end_overrun;

    always #4 clk = ~clk;

    ctl_tlv_parser u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .in_sop(in_sop), .in_eop(in_eop),
        .desc_valid(desc_valid), .desc_key(desc_key), .desc_type(desc_type),
        .desc_len(desc_len), .desc_bad_type(desc_bad_type),
        .val_valid(val_valid), .val_data(val_data), .val_last(val_last),
        .end_valid(end_valid), .end_ok(end_ok), .end_trunc(end_trunc),
        .end_overrun(end_overrun)
    );

    typedef struct { logic [31:0] key; logic [3:0] typ; logic [11:0] len; logic bad; } d_t;
    typedef struct { logic [7:0] data; logic last; } v_t;
    typedef struct { logic ok; logic tr; logic ov; } e_t;

    d_t exp_d[$];
    v_t exp_v[$];
    e_t exp_e[$];
    logic [7:0] pl[$];

    int    checks = 0;
    int    failures = 0;
    string phase = "R10";
    bit    mon_on = 0;
    bit    gap_mode = 0;
    bit    gap_tog = 0;

    // Scoreboard monitor: compares every output item against the queues.
    always @(negedge clk) begin
        if (!rst && mon_on) begin
            if (desc_valid) begin
                checks++;
                if (exp_d.size() == 0) begin
                    failures++;
                    $display("FAIL %s unexpected descriptor: got key=%h typ=%h len=%0d expected none",
                             phase, desc_key, desc_type, desc_len);
                end else begin
                    d_t e;
                    e = exp_d.pop_front();
                    if (desc_key !== e.key || desc_type !== e.typ ||
                        desc_len !== e.len || desc_bad_type !== e.bad) begin
                        failures++;
                        $display("FAIL %s/R1/R4 descriptor: got key=%h typ=%h len=%0d bad=%0b expected key=%h typ=%h len=%0d bad=%0b",
                                 phase, desc_key, desc_type, desc_len, desc_bad_type,
                                 e.key, e.typ, e.len, e.bad);
                    end
                end
            end
            if (val_valid) begin
                checks++;
                if (exp_v.size() == 0) begin
                    failures++;
                    $display("FAIL %s unexpected value byte: got %h expected none", phase, val_data);
                end else begin
                    v_t e;
                    e = exp_v.pop_front();
                    if (val_data !== e.data || val_last !== e.last) begin
                        failures++;
                        $display("FAIL %s/R2 value: got data=%h last=%0b expected data=%h last=%0b",
                                 phase, val_data, val_last, e.data, e.last);
                    end
                end
            end
            if (end_valid) begin
                checks++;
                if (exp_e.size() == 0) begin
                    failures++;
                    $display("FAIL %s unexpected end report: got ok=%0b tr=%0b ov=%0b expected none",
                             phase, end_ok, end_trunc, end_overrun);
                end else begin
                    e_t e;
                    e = exp_e.pop_front();
                    if (end_ok !== e.ok || end_trunc !== e.tr || end_overrun !== e.ov) begin
                        failures++;
                        $display("FAIL %s/R6 end report: got ok=%0b tr=%0b ov=%0b expected ok=%0b tr=%0b ov=%0b",
                                 phase, end_ok, end_trunc, end_overrun, e.ok, e.tr, e.ov);
                    end
                end
            end
        end
    end

    task automatic put(input logic [7:0] b, input logic s, input logic e);
        if (gap_mode && gap_tog) begin
            @(negedge clk);
            in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
        end
        gap_tog = !gap_tog;
        @(negedge clk);
        in_valid = 1'b1; in_data = b; in_sop = s; in_eop = e;
    endtask

    task automatic hdr(input logic [31:0] key, input logic [3:0] typ,
                       input logic [11:0] len, input bit emit);
        d_t d;
        pl.push_back(key[31:24]); pl.push_back(key[23:16]);
        pl.push_back(key[15:8]);  pl.push_back(key[7:0]);
        pl.push_back({typ, len[11:8]}); pl.push_back(len[7:0]);
        if (emit) begin
            d.key = key; d.typ = typ; d.len = len;
            d.bad = (typ >= 4'h4) && (typ <= 4'hE);
            exp_d.push_back(d);
        end
    endtask

    task automatic vals(input int n, input logic [7:0] seed, input bit with_last);
        for (int i = 0; i < n; i++) begin
            v_t v;
            v.data = seed + 8'(i);
            v.last = with_last && (i == n - 1);
            pl.push_back(v.data);
            exp_v.push_back(v);
        end
    endtask

    task automatic term();
        hdr(32'h0, 4'h0, 12'h0, 0);
    endtask

    task automatic expect_end(input logic ok, input logic tr, input logic ov);
        e_t e;
        e.ok = ok; e.tr = tr; e.ov = ov;
        exp_e.push_back(e);
    endtask

    task automatic send(input bit with_eop);
        for (int i = 0; i < pl.size(); i++)
            put(pl[i], i == 0, with_eop && (i == pl.size() - 1));
        pl.delete();
    endtask

    task automatic finish_phase();
        @(negedge clk);
        in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
        repeat (4) @(negedge clk);
        checks++;
        if (exp_d.size() != 0 || exp_v.size() != 0 || exp_e.size() != 0) begin
            failures++;
            $display("FAIL %s missing outputs: got pending d=%0d v=%0d e=%0d expected 0 0 0",
                     phase, exp_d.size(), exp_v.size(), exp_e.size());
            exp_d.delete(); exp_v.delete(); exp_e.delete();
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: got hung run expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R10: outputs quiet during and right after reset
        repeat (3) @(negedge clk);
        checks++;
        if ({desc_valid, val_valid, val_last, end_valid, end_ok, end_trunc, end_overrun} !== 7'b0) begin
            failures++;
            $display("FAIL R10 reset outputs: got %b expected 0000000",
                     {desc_valid, val_valid, val_last, end_valid, end_ok, end_trunc, end_overrun});
        end
        rst = 1'b0;
        @(negedge clk);
        checks++;
        if ({desc_valid, val_valid, end_valid} !== 3'b0) begin
            failures++;
            $display("FAIL R10 after reset: got %b expected 000", {desc_valid, val_valid, end_valid});
        end
        mon_on = 1;

        // R1 R2 R6: two records then terminator, clean end
        phase = "R1";
        hdr(32'h53534944, 4'h1, 12'd5, 1); vals(5, 8'h41, 1);
        hdr(32'h00000001, 4'h2, 12'd4, 1); vals(4, 8'h10, 1);
        term(); expect_end(1, 0, 0);
        send(1); finish_phase();

        // R1: length above 255 exercises the upper length nibble
        phase = "R1_long";
        hdr(32'hCAFE0102, 4'hF, 12'h12C, 1); vals(300, 8'h80, 1);
        term(); expect_end(1, 0, 0);
        send(1); finish_phase();

        // R3 R5: zero-length record, then bytes after the terminator
        phase = "R3";
        hdr(32'h4C454E30, 4'h3, 12'd0, 1);
        hdr(32'h00000000, 4'h3, 12'd2, 1); vals(2, 8'hE0, 1);
        term();
        pl.push_back(8'h11); pl.push_back(8'h22); pl.push_back(8'h33);
        expect_end(1, 0, 0);
        send(1); finish_phase();

        // R4 R11: reserved types skipped by length, idle gaps between bytes
        phase = "R4";
        gap_mode = 1;
        hdr(32'h52535635, 4'h5, 12'd3, 1); vals(3, 8'h50, 1);
        hdr(32'h5253560E, 4'hE, 12'd1, 1); vals(1, 8'h60, 1);
        hdr(32'h50545246, 4'hF, 12'd2, 1); vals(2, 8'h70, 1);
        hdr(32'h5A45524F, 4'h0, 12'd1, 1); vals(1, 8'h90, 1);
        term(); expect_end(1, 0, 0);
        send(1); finish_phase();
        gap_mode = 0;

        // R7: end in the middle of a header
        phase = "R7_midhdr";
        hdr(32'h41424344, 4'h1, 12'd2, 1); vals(2, 8'h30, 1);
        pl.push_back(8'h45); pl.push_back(8'h46); pl.push_back(8'h47);
        expect_end(0, 1, 0);
        send(1); finish_phase();

        // R7: end exactly at a record boundary
        phase = "R7_boundary";
        hdr(32'h41424345, 4'h2, 12'd3, 1); vals(3, 8'hA0, 1);
        expect_end(0, 1, 0);
        send(1); finish_phase();

        // R8: end with value bytes still owed; no val_last
        phase = "R8_midval";
        hdr(32'h4F565231, 4'h1, 12'd6, 1); vals(2, 8'hC0, 0);
        expect_end(0, 0, 1);
        send(1); finish_phase();

        // R8: end on the sixth header byte of a nonzero-length record
        phase = "R8_onhdr";
        hdr(32'h4F565232, 4'h1, 12'd3, 1);
        expect_end(0, 0, 1);
        send(1); finish_phase();

        // R9: stray bytes outside a payload, then a restart mid-record
        phase = "R9";
        put(8'hAA, 0, 0); put(8'h00, 0, 0); put(8'hBB, 0, 1);
        hdr(32'h4B455931, 4'h1, 12'd4, 1); vals(2, 8'h20, 0);
        send(0);
        hdr(32'h4B455932, 4'h2, 12'd1, 1); vals(1, 8'h77, 1);
        term(); expect_end(1, 0, 0);
        send(1);
        put(8'hCC, 0, 0); put(8'hDD, 0, 1);
        finish_phase();

        // R9 R7: single-byte payload with start and end together
        phase = "R9_single";
        put(8'h00, 1, 1);
        expect_end(0, 1, 0);
        finish_phase();

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule